// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Comparator Unit

This block sits beside a processor core and lets a debugger stop execution on chosen events. It holds two instruction-address comparators, which watch the fetch address, and two data-address comparators, which watch the data access bus. A single 32-bit control word holds the enables, the supervisor-only qualifiers for the instruction comparators, an 8-bit address-space qualifier for each data comparator, a shared access-type selector, the value-condition and value-mask switches, and a single-step switch.

When any enabled comparator matches, or single-step is on and an instruction completes, the unit records the cause in sticky status bits and raises a one-cycle trap request on the following cycle. Software reads and writes every register through a small synchronous register port. Status bits are cleared by writing 1 to them.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset the control register and the status register read 0 and `trap_req` is low.
- R2: Register select codes are: 0 control, 1 status, 2 and 3 instruction address 0 and 1, 4 and 5 data address 0 and 1, 6 value register 1, 7 value register 2. Codes 8 to 15 read 0. A write takes effect on the clock edge. Control bits 13:9 are not implemented and read 0.
- R3: Instruction comparator 0 (enable at control bit 5) and comparator 1 (enable at bit 6) match when `fetch_valid` is high and `fetch_addr` equals their address register. A match sets status bit 0 or bit 1. A comparator with its enable clear never matches.
- R4: With control bit 14 (comparator 0) or bit 15 (comparator 1) set, that instruction comparator matches only when `fetch_super` is high.
- R5: Data comparator 0 (enable at control bit 7, address-space field at bits 23:16) and comparator 1 (enable at bit 8, field at bits 31:24) match only when `dbus_addr` equals their address register and `dbus_asi` equals their field. A match sets status bit 4 or bit 5. A comparator with its enable clear never matches.
- R6: Control bits 3:2 choose which accesses qualify. 00 means a valid read (`dbus_write`=0). 01 means a valid write. 10 means any valid access. 11 means every cycle, whether or not `dbus_valid` is high.
- R7: With control bit 1 set, a data match also needs a value test. With control bit 0 set, the test passes when (`dbus_data` XOR value1) AND NOT value2 is zero. With bit 0 clear, the test passes when `dbus_data` equals value1. With bit 1 clear the data value is ignored.
- R8: With control bit 4 set, a high `step_done` sets status bit 2.
- R9: `trap_req` is high in the cycle after each cycle in which at least one event (R3, R5, R8) occurs, and low otherwise. The status bit for that event is visible in the same cycle.
- R10: Status bits are sticky. A write to the status register clears those bits written as 1. If an event occurs in the same cycle as the clear, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 4 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fetch_valid | input | 1 | Instruction fetch in progress |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_super | input | 1 | Fetch made in supervisor state |
| step_done | input | 1 | One instruction completed |
| dbus_valid | input | 1 | Data access in progress |
| dbus_write | input | 1 | 1 = write, 0 = read |
| dbus_addr | input | ADDR_W | Data access address |
| dbus_asi | input | 8 | Address-space ID of the access |
| dbus_data | input | 32 | Data value of the access |
| trap_req | output | 1 | Debug trap request |

## Verification
The data comparators are driven from a table of accesses. Each entry changes one factor against a matching baseline: read against write under each type code, a wrong address-space ID, an off-by-four address, a cleared enable, exact and masked value tests that pass or fail, and "always" mode with no valid access. Each entry therefore shows that one qualifier really gates the match. Directed sequences then test the instruction comparators with and without the supervisor qualifier, single-step, sticky status with write-1-to-clear against a same-cycle event, register readback and reset.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
   localparam int REG_W = 32;
   localparam int ASI_W = 8;
   localparam int SEL_W = 4;
   localparam int N_CMP = 2;
   localparam int STAT_W = 6;

   typedef enum logic [SEL_W-1:0] {
      RS_CTRL = 4'd0,
      RS_STAT = 4'd1,
      RS_IA0  = 4'd2,
      RS_IA1  = 4'd3,
      RS_DA0  = 4'd4,
      RS_DA1  = 4'd5,
      RS_VAL1 = 4'd6,
      RS_VAL2 = 4'd7
   } rsel_e;

   // control word bit positions
   localparam int C_VMASK  = 0;
   localparam int C_VCOND  = 1;
   localparam int C_TYPE   = 2;   // two bits
   localparam int C_STEP   = 4;
   localparam int C_IEN0   = 5;   // +1 for comparator 1
   localparam int C_DEN0   = 7;   // +1 for comparator 1
   localparam int C_ISUP0  = 14;  // +1 for comparator 1
   localparam int C_ASI0   = 16;  // +ASI_W for comparator 1
   localparam logic [REG_W-1:0] CTRL_MASK = 32'hFFFF_C1FF;

   // status bit positions
   localparam int S_IHIT0 = 0;
   localparam int S_STEP  = 2;
   localparam int S_DHIT0 = 4;
endpackage

// File: rtl/dbg_ibrk_cmp.sv
module dbg_ibrk_cmp #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              super_only,
   input  logic [ADDR_W-1:0] cmp_addr,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_super,
   output logic              hit
);
   logic priv_ok;

   always_comb begin
      priv_ok = !super_only || fetch_super;
      hit     = en && fetch_valid && priv_ok && (fetch_addr == cmp_addr);
   end

   // R4: a supervisor-qualified comparator fires only on supervisor fetches
   assert_sup_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && super_only) |-> fetch_super);
endmodule

// File: rtl/dbg_dwatch_cmp.sv
module dbg_dwatch_cmp
   import dbg_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter bit VALUE_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ASI_W-1:0]  cmp_asi,
   input  logic [ADDR_W-1:0] cmp_addr,
   input  logic [1:0]        type_sel,
   input  logic              val_cond,
   input  logic              val_mask,
   input  logic [REG_W-1:0]  val1,
   input  logic [REG_W-1:0]  val2,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [ASI_W-1:0]  bus_asi,
   input  logic [REG_W-1:0]  bus_data,
   output logic              hit
);
   logic type_ok;
   logic value_ok;

   always_comb begin
      unique case (type_sel)
         2'b00:   type_ok = bus_valid && !bus_write;
         2'b01:   type_ok = bus_valid && bus_write;
         2'b10:   type_ok = bus_valid;
         default: type_ok = 1'b1;
      endcase
   end

   generate
      if (VALUE_CMP) begin : g_val
         always_comb begin
            if (!val_cond)
               value_ok = 1'b1;
            else if (val_mask)
               value_ok = ((bus_data ^ val1) & ~val2) == '0;
            else
               value_ok = (bus_data == val1);
         end
      end else begin : g_noval
         assign value_ok = 1'b1;
      end
   endgenerate

   assign hit = en && type_ok && value_ok &&
                (bus_addr == cmp_addr) && (bus_asi == cmp_asi);

   // R6: load-only and store-only modes honour direction
   assert_load_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && type_sel == 2'b00) |-> (bus_valid && !bus_write));
   assert_store_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && type_sel == 2'b01) |-> (bus_valid && bus_write));
   // R7: exact value condition
   assert_exact_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && val_cond && !val_mask && VALUE_CMP) |-> (bus_data == val1));
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
   import dbg_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter bit VALUE_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_super,
   input  logic              step_done,
   input  logic              dbus_valid,
   input  logic              dbus_write,
   input  logic [ADDR_W-1:0] dbus_addr,
   input  logic [ASI_W-1:0]  dbus_asi,
   input  logic [REG_W-1:0]  dbus_data,
   output logic              trap_req
);
   generate
      if (ADDR_W < 2 || ADDR_W > REG_W) begin : g_bad_aw
         $error("ADDR_W must lie in 2..REG_W");
      end
      if (C_ASI0 + N_CMP * ASI_W > REG_W) begin : g_bad_asi
         $error("address-space fields do not fit the control word");
      end
   endgenerate

   logic [REG_W-1:0]  ctrl_q;
   logic [STAT_W-1:0] stat_q;
   logic [REG_W-1:0]  ia_q [N_CMP];
   logic [REG_W-1:0]  da_q [N_CMP];
   logic [REG_W-1:0]  val1_q, val2_q;
   logic [N_CMP-1:0]  ihit, dhit;
   logic              step_ev;
   logic [STAT_W-1:0] ev_vec, clr_vec;
   logic              stat_wr;

   // comparators
   generate
      for (genvar i = 0; i < N_CMP; i++) begin : g_ib
         dbg_ibrk_cmp #(.ADDR_W(ADDR_W)) u_ib (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (ctrl_q[C_IEN0 + i]),
            .super_only (ctrl_q[C_ISUP0 + i]),
            .cmp_addr   (ia_q[i][ADDR_W-1:0]),
            .fetch_valid(fetch_valid),
            .fetch_addr (fetch_addr),
            .fetch_super(fetch_super),
            .hit        (ihit[i])
         );
      end
      for (genvar i = 0; i < N_CMP; i++) begin : g_dw
         dbg_dwatch_cmp #(.ADDR_W(ADDR_W), .VALUE_CMP(VALUE_CMP)) u_dw (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ctrl_q[C_DEN0 + i]),
            .cmp_asi   (ctrl_q[C_ASI0 + i*ASI_W +: ASI_W]),
            .cmp_addr  (da_q[i][ADDR_W-1:0]),
            .type_sel  (ctrl_q[C_TYPE +: 2]),
            .val_cond  (ctrl_q[C_VCOND]),
            .val_mask  (ctrl_q[C_VMASK]),
            .val1      (val1_q),
            .val2      (val2_q),
            .bus_valid (dbus_valid),
            .bus_write (dbus_write),
            .bus_addr  (dbus_addr),
            .bus_asi   (dbus_asi),
            .bus_data  (dbus_data),
            .hit       (dhit[i])
         );
      end
   endgenerate

   assign step_ev = ctrl_q[C_STEP] && step_done;

   always_comb begin
      ev_vec = '0;
      ev_vec[S_IHIT0 +: N_CMP] = ihit;
      ev_vec[S_STEP]           = step_ev;
      ev_vec[S_DHIT0 +: N_CMP] = dhit;
   end

   assign stat_wr = reg_we && (reg_sel == RS_STAT);
   assign clr_vec = stat_wr ? reg_wdata[STAT_W-1:0] : '0;

   // register file
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         stat_q   <= '0;
         val1_q   <= '0;
         val2_q   <= '0;
         trap_req <= 1'b0;
         for (int k = 0; k < N_CMP; k++) begin
            ia_q[k] <= '0;
            da_q[k] <= '0;
         end
      end else begin
         stat_q   <= (stat_q & ~clr_vec) | ev_vec;
         trap_req <= |ev_vec;
         if (reg_we) begin
            unique case (reg_sel)
               RS_CTRL: ctrl_q  <= reg_wdata & CTRL_MASK;
               RS_IA0:  ia_q[0] <= reg_wdata;
               RS_IA1:  ia_q[1] <= reg_wdata;
               RS_DA0:  da_q[0] <= reg_wdata;
               RS_DA1:  da_q[1] <= reg_wdata;
               RS_VAL1: val1_q  <= reg_wdata;
               RS_VAL2: val2_q  <= reg_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (reg_sel)
         RS_CTRL: reg_rdata = ctrl_q;
         RS_STAT: reg_rdata = {{(REG_W-STAT_W){1'b0}}, stat_q};
         RS_IA0:  reg_rdata = ia_q[0];
         RS_IA1:  reg_rdata = ia_q[1];
         RS_DA0:  reg_rdata = da_q[0];
         RS_DA1:  reg_rdata = da_q[1];
         RS_VAL1: reg_rdata = val1_q;
         RS_VAL2: reg_rdata = val2_q;
         default: reg_rdata = '0;
      endcase
   end

   // R9: a trap request always has a recorded cause and a preceding event
   assert_trap_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (stat_q != '0));
   assert_trap_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(ihit != '0 || dhit != '0 || step_ev));
   // R3 / R5: a status bit rises only if its comparator was enabled
   assert_ib_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[S_IHIT0]) |-> $past(ctrl_q[C_IEN0]));
   assert_dw_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[S_DHIT0]) |-> $past(ctrl_q[C_DEN0]));
   // R8: step status needs the step enable
   assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[S_STEP]) |-> $past(ctrl_q[C_STEP] && step_done));
   // R10: a set bit stays set unless software clears it
   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[S_DHIT0] && !clr_vec[S_DHIT0]) |=> stat_q[S_DHIT0]);
endmodule

// File: tb/tb_dbg_watch_unit.sv
module tb_dbg_watch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_sel = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_addr = 32'hFFFF_FFF0;
   logic        fetch_super = 1'b0;
   logic        step_done = 1'b0;
   logic        dbus_valid = 1'b0;
   logic        dbus_write = 1'b0;
   logic [31:0] dbus_addr = 32'hFFFF_FFF0;
   logic [7:0]  dbus_asi = '0;
   logic [31:0] dbus_data = '0;
   logic        trap_req;

   int total = 0;
   int bad   = 0;
   logic [31:0] rv;

   always #10 clk = ~clk;   // 50 MHz

   dbg_watch_unit dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .fetch_super(fetch_super), .step_done(step_done),
      .dbus_valid(dbus_valid), .dbus_write(dbus_write),
      .dbus_addr(dbus_addr), .dbus_asi(dbus_asi), .dbus_data(dbus_data),
      .trap_req(trap_req)
   );

   typedef struct packed {
      logic [31:0] ctrl;
      logic [31:0] v1;
      logic [31:0] v2;
      logic        valid;
      logic        wr;
      logic [31:0] addr;
      logic [7:0]  asi;
      logic [31:0] data;
      logic [1:0]  exp;   // expected status bits 5:4
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{32'h000B_0080, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h1000, 8'h0B, 32'h0, 2'b01}, // R6 load, load
      '{32'h000B_0080, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'h1000, 8'h0B, 32'h0, 2'b00}, // R6 load, store
      '{32'h000B_0084, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'h1000, 8'h0B, 32'h0, 2'b01}, // R6 store
      '{32'h000B_0084, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h1000, 8'h0B, 32'h0, 2'b00}, // R6 store, load
      '{32'h000B_0088, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h1000, 8'h0B, 32'h0, 2'b01}, // R6 any
      '{32'h000B_0088, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h1000, 8'h0A, 32'h0, 2'b00}, // R5 asi
      '{32'h000B_0088, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h1004, 8'h0B, 32'h0, 2'b00}, // R5 addr
      '{32'h000B_0008, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h1000, 8'h0B, 32'h0, 2'b00}, // R5 disabled
      '{32'h0B00_0108, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'h2000, 8'h0B, 32'h0, 2'b10}, // R5 cmp1
      '{32'h0B0B_0188, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'h1000, 8'h0B, 32'h0, 2'b01}, // R5 both on
      '{32'h000B_008A, 32'h55, 32'h0, 1'b1, 1'b0, 32'h1000, 8'h0B, 32'h55, 2'b01},      // R7 exact ok
      '{32'h000B_008A, 32'h55, 32'h0, 1'b1, 1'b0, 32'h1000, 8'h0B, 32'h56, 2'b00},      // R7 exact bad
      '{32'h000B_008B, 32'h50, 32'h0F, 1'b1, 1'b0, 32'h1000, 8'h0B, 32'h5A, 2'b01},     // R7 mask ok
      '{32'h000B_008B, 32'h50, 32'h0F, 1'b1, 1'b0, 32'h1000, 8'h0B, 32'h6A, 2'b00},     // R7 mask bad
      '{32'h000B_008C, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h1000, 8'h0B, 32'h0, 2'b01}, // R6 always
      '{32'h000B_0088, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h1000, 8'h0B, 32'h0, 2'b00}  // R6 any, idle
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] sel, output logic [31:0] d);
      reg_sel = sel;
      #1;
      d = reg_rdata;
   endtask

   task automatic idle();
      fetch_valid = 1'b0; fetch_addr = 32'hFFFF_FFF0; fetch_super = 1'b0;
      step_done = 1'b0; dbus_valid = 1'b0; dbus_write = 1'b0;
      dbus_addr = 32'hFFFF_FFF0; dbus_asi = '0; dbus_data = '0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 trap", {31'b0, trap_req}, 32'h0);
      rd(4'd0, rv); check("R1 ctrl", rv, 32'h0);
      rd(4'd1, rv); check("R1 status", rv, 32'h0);

      // R2 readback
      wr(4'd2, 32'h0000_0400);
      wr(4'd3, 32'h0000_0800);
      wr(4'd4, 32'h0000_1000);
      wr(4'd5, 32'h0000_2000);
      wr(4'd6, 32'hA5A5_0001);
      rd(4'd2, rv); check("R2 ia0", rv, 32'h400);
      rd(4'd5, rv); check("R2 da1", rv, 32'h2000);
      rd(4'd6, rv); check("R2 val1", rv, 32'hA5A5_0001);
      rd(4'd8, rv); check("R2 unmapped", rv, 32'h0);
      wr(4'd0, 32'h0000_3E00);
      rd(4'd0, rv); check("R2 ctrl gaps", rv, 32'h0);

      // data comparator table
      for (int i = 0; i < NV; i++) begin
         wr(4'd1, 32'h3F);
         wr(4'd6, VECS[i].v1);
         wr(4'd7, VECS[i].v2);
         wr(4'd0, VECS[i].ctrl);
         @(negedge clk);
         dbus_valid = VECS[i].valid; dbus_write = VECS[i].wr;
         dbus_addr = VECS[i].addr; dbus_asi = VECS[i].asi; dbus_data = VECS[i].data;
         @(negedge clk);
         idle();
         rd(4'd1, rv);
         check($sformatf("R5/R6/R7 vec%0d status", i), rv, {26'b0, VECS[i].exp, 4'b0});
         check($sformatf("R9 vec%0d trap", i), {31'b0, trap_req}, {31'b0, |VECS[i].exp});
      end
      wr(4'd1, 32'h3F);

      // R3 instruction comparator 0
      wr(4'd0, 32'h0000_0020);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 32'h400;
      @(negedge clk);
      idle();
      rd(4'd1, rv); check("R3 ib0 status", rv, 32'h01);
      check("R9 ib0 trap", {31'b0, trap_req}, 32'h1);
      @(negedge clk);
      check("R9 trap one cycle", {31'b0, trap_req}, 32'h0);
      rd(4'd1, rv); check("R10 sticky", rv, 32'h01);
      // comparator 1 disabled
      fetch_valid = 1'b1; fetch_addr = 32'h800;
      @(negedge clk);
      idle();
      rd(4'd1, rv); check("R3 ib1 disabled", rv, 32'h01);
      check("R3 ib1 disabled trap", {31'b0, trap_req}, 32'h0);

      // R10 write-1-to-clear and set priority
      wr(4'd0, 32'h0000_0060);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 32'h800;
      @(negedge clk);
      idle();
      rd(4'd1, rv); check("R3 ib1 status", rv, 32'h03);
      wr(4'd1, 32'h01);
      rd(4'd1, rv); check("R10 partial clear", rv, 32'h02);
      @(negedge clk);
      reg_sel = 4'd1; reg_we = 1'b1; reg_wdata = 32'h02;
      fetch_valid = 1'b1; fetch_addr = 32'h800;
      @(negedge clk);
      reg_we = 1'b0; idle();
      rd(4'd1, rv); check("R10 set wins", rv, 32'h02);
      wr(4'd1, 32'h3F);
      rd(4'd1, rv); check("R10 clear all", rv, 32'h00);

      // R4 supervisor qualifier
      wr(4'd0, 32'h0000_4020);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 32'h400; fetch_super = 1'b0;
      @(negedge clk);
      idle();
      rd(4'd1, rv); check("R4 user fetch", rv, 32'h00);
      fetch_valid = 1'b1; fetch_addr = 32'h400; fetch_super = 1'b1;
      @(negedge clk);
      idle();
      rd(4'd1, rv); check("R4 super fetch", rv, 32'h01);
      wr(4'd1, 32'h3F);

      // R8 single step
      wr(4'd0, 32'h0000_0000);
      @(negedge clk);
      step_done = 1'b1;
      @(negedge clk);
      idle();
      rd(4'd1, rv); check("R8 step off", rv, 32'h00);
      wr(4'd0, 32'h0000_0010);
      @(negedge clk);
      step_done = 1'b1;
      @(negedge clk);
      idle();
      rd(4'd1, rv); check("R8 step status", rv, 32'h04);
      check("R8 step trap", {31'b0, trap_req}, 32'h1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule